// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers level interrupt requests from six on-chip sources (a serial flash controller, two two-wire bus controllers, two DMA channels and a common-interface slot controller) and folds them into one registered, level-sensitive interrupt line toward the host bridge. A per-source mask selects which requests may reach the line. The mask is never written directly: one alias address ORs ones into it, another alias address clears the bits written as one. A separate global enable gates the final output. The host typically drops it on entry to its service routine and raises it again on exit.

Software reaches the block through a plain synchronous register port. A write is taken at the clock edge while the write strobe is high. Read data is combinational from the address. A global status word reports whether any unmasked source is pending, whatever the global enable says. A per-source status word shows which unmasked sources are active. Each source clears its own request inside its own logic, so the aggregator holds no pending state of its own.

Top module: `irq_collector`

## Requirements
- R1: Reset (rst_ni low, asynchronous) forces host_irq_o to 0, the mask to 0 and the global enable to 0; during and after reset every register reads 0.
- R2: A write to offset 0x48 ORs the low 16 data bits into the mask; zero bits leave mask bits unchanged; reading 0x48 returns the mask.
- R3: A write to offset 0x4C clears every mask bit written as one (0xFFFF clears the whole mask); reading 0x4C returns the mask.
- R4: Offset 0x60 reads the per-source status: bit i is src_i[i] AND mask bit i, with SPI flash = bit 0, two-wire bus 0 = bit 1, two-wire bus 1 = bit 2, DMA channel 0 = bit 3, DMA channel 1 = bit 4, common interface = bit 5; all other bits read 0.
- R5: Offset 0x40 reads 0x80 (bit 7) whenever any masked source is active, independent of the global enable, and 0 otherwise.
- R6: Offset 0x50 holds the global enable in bit 7; other written bits are ignored; it reads back 0x80 when enabled, else 0.
- R7: host_irq_o is a register that, at each clock edge, takes the new global enable AND the OR of src_i with the new mask; a write of 0 to 0x50 therefore forces it low at that same edge, and a write of 0x80 raises it there if a masked source is active.
- R8: Writes to 0x40, 0x60 or any unmapped offset change nothing; reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC (6) | Level requests from the sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (16) | Register byte offset |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data, combinational |
| host_irq_o | output | 1 | Registered level interrupt to the host bridge |

## Verification
Two things can meet at one clock edge: a register write to the enable or mask aliases and a change on a source line. The bench drives both on the same falling edge. In one case it writes 0 to the enable while all six sources rise. In another it clears the mask through its alias while sources stay active. It then judges host_irq_o just after the next rising edge, where the write must win and the line must stay low. A reverse case writes the enable back to 0x80 together with active sources and expects the line high at that same edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam logic [15:0] OFF_GSTAT = 16'h0040;
  localparam logic [15:0] OFF_MSET  = 16'h0048;
  localparam logic [15:0] OFF_MCLR  = 16'h004C;
  localparam logic [15:0] OFF_GEN   = 16'h0050;
  localparam logic [15:0] OFF_SSTAT = 16'h0060;

  localparam int unsigned HOST_EN_BIT = 7;

  localparam int unsigned SRC_SPI  = 0;
  localparam int unsigned SRC_TWI0 = 1;
  localparam int unsigned SRC_TWI1 = 2;
  localparam int unsigned SRC_DMA0 = 3;
  localparam int unsigned SRC_DMA1 = 4;
  localparam int unsigned SRC_CI   = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GSTAT,
    SEL_MSET,
    SEL_MCLR,
    SEL_GEN,
    SEL_SSTAT
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              gen_we_o,
  output logic              mset_we_o,
  output logic              mclr_we_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_GSTAT)) sel_o = SEL_GSTAT;
    else if (addr_i == ADDR_W'(OFF_MSET))  sel_o = SEL_MSET;
    else if (addr_i == ADDR_W'(OFF_MCLR))  sel_o = SEL_MCLR;
    else if (addr_i == ADDR_W'(OFF_GEN))   sel_o = SEL_GEN;
    else if (addr_i == ADDR_W'(OFF_SSTAT)) sel_o = SEL_SSTAT;
  end

  // status registers are read-only: no strobe for them
  assign gen_we_o  = we_i && (sel_o == SEL_GEN);
  assign mset_we_o = we_i && (sel_o == SEL_MSET);
  assign mclr_we_o = we_i && (sel_o == SEL_MCLR);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic [MASK_W-1:0] set_bits_i,
  input  logic              clr_we_i,
  input  logic [MASK_W-1:0] clr_bits_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [MASK_W-1:0] mask_next_o
);
  logic [MASK_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_we_i) mask_d = mask_d | set_bits_i;
    if (clr_we_i) mask_d = mask_d & ~clr_bits_i;  // clear wins on overlap
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o      = mask_q;
  assign mask_next_o = mask_d;

  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((mask_q & $past(set_bits_i)) == $past(set_bits_i)));

  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(mask_q));

  assert_mask_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((mask_q & $past(clr_bits_i)) == '0));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_we_i,
  input  logic en_wbit_i,
  input  logic pend_next_i,
  output logic en_o,
  output logic irq_o
);
  logic en_q, en_d, irq_q;

  assign en_d = en_we_i ? en_wbit_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= en_d & pend_next_i;
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_q);

  assert_irq_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !en_wbit_i) |=> !irq_q);

  assert_irq_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && en_wbit_i && pend_next_i) |=> irq_q);

  assert_en_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned MASK_W  = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               host_irq_o
);
  reg_sel_e          sel;
  logic              gen_we, mset_we, mclr_we;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [MASK_W-1:0] src_stat, src_pend_d;
  logic              any_now, any_next, en_q;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .sel_o     (sel),
    .gen_we_o  (gen_we),
    .mset_we_o (mset_we),
    .mclr_we_o (mclr_we)
  );

  irq_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_we_i    (mset_we),
    .set_bits_i  (reg_wdata_i[MASK_W-1:0]),
    .clr_we_i    (mclr_we),
    .clr_bits_i  (reg_wdata_i[MASK_W-1:0]),
    .mask_o      (mask_q),
    .mask_next_o (mask_d)
  );

  for (genvar i = 0; i < MASK_W; i++) begin : g_src
    if (i < NUM_SRC) begin : g_used
      assign src_stat[i]   = src_i[i] & mask_q[i];
      assign src_pend_d[i] = src_i[i] & mask_d[i];
    end else begin : g_spare
      assign src_stat[i]   = 1'b0;
      assign src_pend_d[i] = 1'b0;
    end
  end

  assign any_now  = |src_stat;
  assign any_next = |src_pend_d;

  irq_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_we_i     (gen_we),
    .en_wbit_i   (reg_wdata_i[HOST_EN_BIT]),
    .pend_next_i (any_next),
    .en_o        (en_q),
    .irq_o       (host_irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_GSTAT:         reg_rdata_o[HOST_EN_BIT] = any_now;
      SEL_GEN:           reg_rdata_o[HOST_EN_BIT] = en_q;
      SEL_MSET, SEL_MCLR: reg_rdata_o[MASK_W-1:0] = mask_q;
      SEL_SSTAT:         reg_rdata_o[MASK_W-1:0] = src_stat;
      default:           reg_rdata_o = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i, mask_d};

  assert_stat_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_SSTAT) |-> ((reg_rdata_o[MASK_W-1:0] & ~mask_q) == '0));

  assert_gstat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_GSTAT) |-> (reg_rdata_o[HOST_EN_BIT] == (|(src_i & mask_q[NUM_SRC-1:0]))));
endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src = '0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_collector u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .host_irq_o  (irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [5:0]  src;
    logic        exp_irq;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 27;
  // req, rd, addr, data, src, irq after edge, read value
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 8'h48, 16'h0009, 6'h00, 1'b0, 16'h0000}, // R2 set 0,3
    '{4'd2, 1'b1, 8'h48, 16'h0000, 6'h00, 1'b0, 16'h0009},
    '{4'd2, 1'b0, 8'h48, 16'h0020, 6'h00, 1'b0, 16'h0000},
    '{4'd2, 1'b1, 8'h48, 16'h0000, 6'h00, 1'b0, 16'h0029}, // R2 zeros keep
    '{4'd3, 1'b0, 8'h4C, 16'h0001, 6'h00, 1'b0, 16'h0000},
    '{4'd3, 1'b1, 8'h4C, 16'h0000, 6'h00, 1'b0, 16'h0028}, // R3
    '{4'd4, 1'b1, 8'h60, 16'h0000, 6'h08, 1'b0, 16'h0008}, // R4 DMA0
    '{4'd5, 1'b1, 8'h40, 16'h0000, 6'h08, 1'b0, 16'h0080}, // R5 enable off
    '{4'd6, 1'b0, 8'h50, 16'h00FF, 6'h08, 1'b1, 16'h0000}, // R6/R7
    '{4'd6, 1'b1, 8'h50, 16'h0000, 6'h08, 1'b1, 16'h0080}, // R6
    '{4'd4, 1'b1, 8'h60, 16'h0000, 6'h01, 1'b0, 16'h0000}, // R4 SPI masked
    '{4'd5, 1'b1, 8'h40, 16'h0000, 6'h01, 1'b0, 16'h0000},
    '{4'd4, 1'b1, 8'h60, 16'h0000, 6'h3F, 1'b1, 16'h0028},
    '{4'd7, 1'b0, 8'h50, 16'h0000, 6'h3F, 1'b0, 16'h0000}, // R7 off
    '{4'd5, 1'b1, 8'h40, 16'h0000, 6'h3F, 1'b0, 16'h0080},
    '{4'd7, 1'b0, 8'h50, 16'h0080, 6'h3F, 1'b1, 16'h0000}, // R7 on
    '{4'd8, 1'b0, 8'h40, 16'hFFFF, 6'h3F, 1'b1, 16'h0000}, // R8
    '{4'd8, 1'b0, 8'h60, 16'hFFFF, 6'h3F, 1'b1, 16'h0000},
    '{4'd8, 1'b0, 8'h10, 16'hFFFF, 6'h3F, 1'b1, 16'h0000},
    '{4'd8, 1'b1, 8'h48, 16'h0000, 6'h3F, 1'b1, 16'h0028},
    '{4'd8, 1'b1, 8'h50, 16'h0000, 6'h3F, 1'b1, 16'h0080},
    '{4'd8, 1'b1, 8'h10, 16'h0000, 6'h3F, 1'b1, 16'h0000},
    '{4'd3, 1'b0, 8'h4C, 16'hFFFF, 6'h3F, 1'b0, 16'h0000}, // R3 all
    '{4'd3, 1'b1, 8'h48, 16'h0000, 6'h3F, 1'b0, 16'h0000},
    '{4'd4, 1'b0, 8'h48, 16'h0004, 6'h3F, 1'b1, 16'h0000}, // R4 I2C1
    '{4'd4, 1'b1, 8'h60, 16'h0000, 6'h3F, 1'b1, 16'h0004},
    '{4'd5, 1'b1, 8'h40, 16'h0000, 6'h00, 1'b0, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    src   = v.src;
    we    = !v.rd;
    addr  = {8'h00, v.addr};
    wdata = {16'h0000, v.data};
    #1;
    if (v.rd) check(rdata == {16'h0, v.exp_rd}, tag, rdata, {16'h0, v.exp_rd});
    @(posedge clk);
    #1;
    we = 1'b0;
    check(irq == v.exp_irq, tag, {31'h0, irq}, {31'h0, v.exp_irq});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    check(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
    addr = 16'h0048; #1;
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    addr = 16'h0050; #1;
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // same-edge: enable write 0 together with sources rising (R7)
    run_vec('{4'd2, 1'b0, 8'h48, 16'h003F, 6'h00, 1'b0, 16'h0000});
    run_vec('{4'd7, 1'b0, 8'h50, 16'h0000, 6'h3F, 1'b0, 16'h0000});
    run_vec('{4'd7, 1'b0, 8'h50, 16'h0080, 6'h3F, 1'b1, 16'h0000});
    // same-edge: mask clear while sources stay active (R3)
    run_vec('{4'd3, 1'b0, 8'h4C, 16'h003F, 6'h3F, 1'b0, 16'h0000});

    // single-cycle pulse on DMA1 (R7)
    run_vec('{4'd2, 1'b0, 8'h48, 16'h0010, 6'h00, 1'b0, 16'h0000});
    run_vec('{4'd7, 1'b1, 8'h60, 16'h0000, 6'h10, 1'b1, 16'h0010});
    run_vec('{4'd7, 1'b1, 8'h60, 16'h0000, 6'h00, 1'b0, 16'h0000});

    // reset mid-run with line high (R1)
    run_vec('{4'd7, 1'b1, 8'h40, 16'h0000, 6'h10, 1'b1, 16'h0080});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
    addr = 16'h0060; #1;
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    addr = 16'h0050; #1;
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    addr = 16'h004C; #1;
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    @(posedge clk); #1;
    check(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule